// File: doc/BRIEF.md
# Bank Write Auto-Precharge Timer

This block follows the command stream of one bank of a DDR2-style memory controller. It works out when that bank may be opened again after a write that closes the bank by itself. When it sees an activate, it starts the row-cycle and row-active timers. When it sees a write with the auto-precharge flag set, it starts the write-recovery timer.

The internal precharge starts on the first edge at which two conditions hold: the burst has ended and write recovery has run out, and the bank has been open for its minimum active time. The block marks that edge with a one-cycle pulse. It then times the precharge period and raises a ready flag once the bank may take another activate. Ready needs both the end of the precharge period and the end of the row-cycle time from the last activate.

The controller treats the ready flag as a permission signal. The block holds a sticky error when an activate arrives too early. It holds a second sticky error when a write breaks the open/pending sequence. All timing values are static configuration inputs, counted in clock cycles.

Top module: `wap_bank_timer`

## Requirements
- R1: The command input uses this encoding: 2'b00 idle, 2'b01 activate, 2'b10 write, 2'b11 ignored. After reset, bank_state reads 2'b00 (closed), act_ready is 1, and pre_start, act_violation and proto_err are 0.
- R2: Take a write (code 2'b10 with cmd_ap=1) accepted at edge E while the bank is open (bank_state 2'b01) and no auto-precharge is pending. If the row-active limit is already met, pre_start is high in exactly the cycle that follows edge E + cfg_wl + cfg_bl/2 + cfg_wr.
- R3: The internal precharge never starts before the edge cfg_tras cycles after the activate edge. When that edge is later than the one in R2, pre_start follows it.
- R4: cfg_err is 1 exactly when cfg_wr is below 2 or above 6.
- R5: Let P be the edge of the internal precharge. The earliest edge that accepts an activate is P + cfg_trp, which gives a spacing of cfg_wl + cfg_bl/2 + cfg_wr + cfg_trp from the write. act_ready is 1 from the cycle before that edge onward.
- R6: pre_start lasts exactly one cycle. During the precharge period bank_state reads 2'b10, and it reads 2'b00 once cfg_trp cycles have passed from P.
- R7: An activate is also refused until the edge cfg_trc cycles after the previous accepted activate. When that edge is later than the one in R5, it alone sets the point at which act_ready rises.
- R8: act_ready is 0 from an accepted activate until the later of the R5 and R7 points. An activate seen while act_ready is 0 sets act_violation, which stays at 1 until reset. Such an activate leaves the bank state and all timers unchanged.
- R9: A write with cmd_ap=0 leaves the bank open and starts no precharge. A write while the bank is not open, or while an auto-precharge is pending, sets the sticky proto_err and is otherwise ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command code for this cycle |
| cmd_ap | input | 1 | Auto-precharge flag qualifying a write |
| cfg_wl | input | CW | Write latency in cycles |
| cfg_bl | input | CW | Burst length in beats |
| cfg_wr | input | CW | Write recovery in cycles |
| cfg_trp | input | CW | Precharge period in cycles |
| cfg_tras | input | CW | Minimum activate-to-precharge time |
| cfg_trc | input | CW | Minimum activate-to-activate time |
| pre_start | output | 1 | One-cycle pulse when the internal precharge starts |
| act_ready | output | 1 | The bank may be activated at the next edge |
| act_violation | output | 1 | Sticky: an activate arrived while not ready |
| proto_err | output | 1 | Sticky: illegal write sequence |
| cfg_err | output | 1 | Write recovery value outside its legal range |
| bank_state | output | 2 | 00 closed, 01 open, 10 precharging |

## Verification
The main timing path is exercised with four configurations, and each one puts a different limit in charge. Two write latencies (2 and 4) are run with short row limits, so only the burst plus recovery plus precharge sum governs; the two runs must differ by exactly the latency step. A long row-cycle value moves only the ready edge and leaves the pulse where it was. A long row-active value moves the pulse, and the ready edge moves with it. Early activates, repeated auto-precharge writes, writes to a closed bank and plain writes each leave a distinct mark on the sticky flags or the bank state. In every one of those cases the pulse timing set earlier must stay unchanged.

// File: rtl/wap_pkg.sv
package wap_pkg;

   typedef enum logic [1:0] {
      BK_IDLE = 2'b00,
      BK_OPEN = 2'b01,
      BK_PREC = 2'b10
   } bank_st_t;

   typedef enum logic [1:0] {
      OP_NOP = 2'b00,
      OP_ACT = 2'b01,
      OP_WR  = 2'b10,
      OP_RSV = 2'b11
   } cmd_op_t;

   localparam int NUM_TMR = 4;
   localparam int TI_RC   = 0;
   localparam int TI_RAS  = 1;
   localparam int TI_WR   = 2;
   localparam int TI_RP   = 3;

endpackage

// File: rtl/wap_countdown.sv
module wap_countdown #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] len,
   output logic          expired
);

   logic [TW-1:0] cnt_q;

   if (TW < 2) begin : g_bad_width
      $error("wap_countdown: TW must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= (len == '0) ? '0 : len - TW'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - TW'(1);
      end
   end

   assign expired = (cnt_q == '0);

   // R5: a running count falls by one per cycle until reloaded
   p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == ($past(cnt_q) - TW'(1))));

   // R5: once expired and not reloaded it stays expired
   p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && expired) |=> expired);

endmodule

// File: rtl/wap_cfg_check.sv
module wap_cfg_check #(
   parameter int CW     = 6,
   parameter int WR_MIN = 2,
   parameter int WR_MAX = 6
) (
   input  logic [CW-1:0] wr,
   output logic          bad
);

   if (WR_MIN > WR_MAX) begin : g_bad_range
      $error("wap_cfg_check: WR_MIN above WR_MAX");
   end
   if (WR_MAX >= (1 << CW)) begin : g_bad_fit
      $error("wap_cfg_check: WR_MAX does not fit CW bits");
   end

   always_comb begin
      bad = (wr < CW'(WR_MIN)) || (wr > CW'(WR_MAX));
   end

endmodule

// File: rtl/wap_bank_fsm.sv
module wap_bank_fsm
   import wap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] op,
   input  logic       ap,
   input  logic       rc_exp,
   input  logic       ras_exp,
   input  logic       wr_exp,
   input  logic       rp_exp,
   output logic       ld_rc,
   output logic       ld_ras,
   output logic       ld_wr,
   output logic       ld_rp,
   output logic       pre_start,
   output logic       act_ready,
   output logic       act_violation,
   output logic       proto_err,
   output logic [1:0] bank_state
);

   bank_st_t st_q;
   logic     ap_pend_q;
   logic     pre_q;
   logic     viol_q;
   logic     perr_q;

   logic is_act, is_wr, act_ok, wr_legal, wr_ap_ok, pre_go;

   always_comb begin
      is_act    = (op == OP_ACT);
      is_wr     = (op == OP_WR);
      act_ready = ((st_q == BK_IDLE) || ((st_q == BK_PREC) && rp_exp)) && rc_exp;
      act_ok    = is_act && act_ready;
      wr_legal  = is_wr && (st_q == BK_OPEN) && !ap_pend_q;
      wr_ap_ok  = wr_legal && ap;
      pre_go    = (st_q == BK_OPEN) && ap_pend_q && wr_exp && ras_exp;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= BK_IDLE;
         ap_pend_q <= 1'b0;
         pre_q     <= 1'b0;
         viol_q    <= 1'b0;
         perr_q    <= 1'b0;
      end else begin
         pre_q <= pre_go;
         if (is_act && !act_ready) viol_q <= 1'b1;
         if (is_wr && !wr_legal)   perr_q <= 1'b1;
         case (st_q)
            BK_IDLE: begin
               if (act_ok) st_q <= BK_OPEN;
            end
            BK_OPEN: begin
               if (wr_ap_ok) ap_pend_q <= 1'b1;
               if (pre_go) begin
                  st_q      <= BK_PREC;
                  ap_pend_q <= 1'b0;
               end
            end
            BK_PREC: begin
               if (act_ok)      st_q <= BK_OPEN;
               else if (rp_exp) st_q <= BK_IDLE;
            end
            default: st_q <= BK_IDLE;
         endcase
      end
   end

   assign ld_rc         = act_ok;
   assign ld_ras        = act_ok;
   assign ld_wr         = wr_ap_ok;
   assign ld_rp         = pre_go;
   assign pre_start     = pre_q;
   assign act_violation = viol_q;
   assign proto_err     = perr_q;
   assign bank_state    = st_q;

   // R6: the precharge-start pulse never lasts two cycles
   p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q |=> !pre_q);

   // R6: the pulse coincides with the precharging state
   p_pulse_in_prec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q |-> (st_q == BK_PREC));

   // R8: an accepted activate drops readiness on the next cycle
   p_act_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      act_ok |=> !act_ready);

   // R8: no activate is permitted while the row is open
   p_open_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BK_OPEN) |-> !act_ready);

   // R8: violation flag is sticky
   p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      viol_q |=> viol_q);

   // R9: protocol error flag is sticky
   p_perr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      perr_q |=> perr_q);

endmodule

// File: rtl/wap_bank_timer.sv
module wap_bank_timer
   import wap_pkg::*;
#(
   parameter int CW     = 6,
   parameter int WR_MIN = 2,
   parameter int WR_MAX = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cmd_op,
   input  logic          cmd_ap,
   input  logic [CW-1:0] cfg_wl,
   input  logic [CW-1:0] cfg_bl,
   input  logic [CW-1:0] cfg_wr,
   input  logic [CW-1:0] cfg_trp,
   input  logic [CW-1:0] cfg_tras,
   input  logic [CW-1:0] cfg_trc,
   output logic          pre_start,
   output logic          act_ready,
   output logic          act_violation,
   output logic          proto_err,
   output logic          cfg_err,
   output logic [1:0]    bank_state
);

   localparam int TW = CW + 2;

   if (CW < 3) begin : g_bad_cw
      $error("wap_bank_timer: CW must be at least 3");
   end

   logic [TW-1:0] tmr_len  [NUM_TMR];
   logic          tmr_load [NUM_TMR];
   logic          tmr_exp  [NUM_TMR];

   logic ld_rc, ld_ras, ld_wr, ld_rp;

   always_comb begin
      tmr_len[TI_RC]  = TW'(cfg_trc);
      tmr_len[TI_RAS] = TW'(cfg_tras);
      tmr_len[TI_WR]  = TW'(cfg_wl) + TW'(cfg_bl >> 1) + TW'(cfg_wr);
      tmr_len[TI_RP]  = TW'(cfg_trp);
      tmr_load[TI_RC]  = ld_rc;
      tmr_load[TI_RAS] = ld_ras;
      tmr_load[TI_WR]  = ld_wr;
      tmr_load[TI_RP]  = ld_rp;
   end

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      wap_countdown #(.TW(TW)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (tmr_load[i]),
         .len     (tmr_len[i]),
         .expired (tmr_exp[i])
      );
   end

   wap_cfg_check #(.CW(CW), .WR_MIN(WR_MIN), .WR_MAX(WR_MAX)) u_cfg (
      .wr  (cfg_wr),
      .bad (cfg_err)
   );

   wap_bank_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .op            (cmd_op),
      .ap            (cmd_ap),
      .rc_exp        (tmr_exp[TI_RC]),
      .ras_exp       (tmr_exp[TI_RAS]),
      .wr_exp        (tmr_exp[TI_WR]),
      .rp_exp        (tmr_exp[TI_RP]),
      .ld_rc         (ld_rc),
      .ld_ras        (ld_ras),
      .ld_wr         (ld_wr),
      .ld_rp         (ld_rp),
      .pre_start     (pre_start),
      .act_ready     (act_ready),
      .act_violation (act_violation),
      .proto_err     (proto_err),
      .bank_state    (bank_state)
   );

   // R3: the precharge pulse implies the row-active timer had run out
   p_ras_met_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pre_start) |-> $past(tmr_exp[TI_RAS]));

   // R7: readiness implies the row-cycle timer has run out
   p_rc_met_r7: assert property (@(posedge clk) disable iff (!rst_n)
      act_ready |-> tmr_exp[TI_RC]);

endmodule

// File: tb/sim_wap_bank_timer.sv
`timescale 1ns/1ps
module sim_wap_bank_timer;

   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic          cmd_ap = 1'b0;
   logic [CW-1:0] cfg_wl = 6'd2, cfg_bl = 6'd4, cfg_wr = 6'd3;
   logic [CW-1:0] cfg_trp = 6'd3, cfg_tras = 6'd1, cfg_trc = 6'd1;
   logic          pre_start, act_ready, act_violation, proto_err, cfg_err;
   logic [1:0]    bank_state;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wap_bank_timer #(.CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_ap(cmd_ap),
      .cfg_wl(cfg_wl), .cfg_bl(cfg_bl), .cfg_wr(cfg_wr),
      .cfg_trp(cfg_trp), .cfg_tras(cfg_tras), .cfg_trc(cfg_trc),
      .pre_start(pre_start), .act_ready(act_ready),
      .act_violation(act_violation), .proto_err(proto_err),
      .cfg_err(cfg_err), .bank_state(bank_state)
   );

   task automatic chk(string req, int actual, int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cmd_op = 2'b00; cmd_ap = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic issue(logic [1:0] op, logic ap);
      cmd_op = op; cmd_ap = ap;
      @(posedge clk);
      @(negedge clk);
      cmd_op = 2'b00; cmd_ap = 1'b0;
   endtask

   task automatic set_cfg(int wl, int bl, int wr, int trp, int tras, int trc);
      cfg_wl = CW'(wl); cfg_bl = CW'(bl); cfg_wr = CW'(wr);
      cfg_trp = CW'(trp); cfg_tras = CW'(tras); cfg_trc = CW'(trc);
   endtask

   // Activate, then write with auto-precharge on the next edge; pulse and ready
   // are observed k edges after the write edge.
   task automatic run_ap(string req, int exp_pre, int exp_rdy);
      do_reset();
      issue(2'b01, 1'b0);
      issue(2'b10, 1'b1);
      for (int k = 0; k <= exp_rdy + 1; k++) begin
         chk({req, " pre_start"}, int'(pre_start), int'(k == exp_pre));
         chk({req, " act_ready"}, int'(act_ready), int'(k >= exp_rdy));
         if (k == exp_pre) chk({req, " state"}, int'(bank_state), 2);
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      set_cfg(2, 4, 3, 3, 1, 1);
      do_reset();
      chk("R1 state", int'(bank_state), 0);
      chk("R1 ready", int'(act_ready), 1);
      chk("R1 pre_start", int'(pre_start), 0);
      chk("R1 violation", int'(act_violation), 0);
      chk("R1 proto", int'(proto_err), 0);
   endtask

   task automatic t_wl2();
      set_cfg(2, 4, 3, 3, 1, 1);
      run_ap("R2 R5 wl2", 7, 9);
      // after tRP from the pulse edge the bank reads closed
      chk("R6 closed", int'(bank_state), 0);
   endtask

   task automatic t_wl4();
      set_cfg(4, 4, 3, 3, 1, 1);
      run_ap("R2 R5 wl4", 9, 11);
   endtask

   task automatic t_trc();
      set_cfg(2, 4, 3, 3, 1, 20);
      run_ap("R7 trc", 7, 18);
   endtask

   task automatic t_tras();
      set_cfg(2, 4, 3, 3, 12, 1);
      run_ap("R3 tras", 11, 13);
   endtask

   task automatic t_reopen();
      set_cfg(2, 4, 3, 3, 1, 1);
      do_reset();
      issue(2'b01, 1'b0);
      issue(2'b10, 1'b1);
      repeat (9) @(negedge clk);
      chk("R6 prec at ready", int'(bank_state), 2);
      issue(2'b01, 1'b0);
      chk("R5 reopen state", int'(bank_state), 1);
      chk("R8 reopen no viol", int'(act_violation), 0);
      chk("R8 reopen ready low", int'(act_ready), 0);
   endtask

   task automatic t_early_act();
      set_cfg(2, 4, 3, 3, 1, 1);
      do_reset();
      issue(2'b01, 1'b0);
      chk("R8 ready low after act", int'(act_ready), 0);
      issue(2'b10, 1'b1);
      issue(2'b01, 1'b0);
      chk("R8 violation set", int'(act_violation), 1);
      chk("R8 state kept", int'(bank_state), 1);
      for (int k = 1; k <= 10; k++) begin
         chk("R8 pulse unchanged", int'(pre_start), int'(k == 7));
         chk("R8 ready unchanged", int'(act_ready), int'(k >= 9));
         @(negedge clk);
      end
      chk("R8 violation sticky", int'(act_violation), 1);
   endtask

   task automatic t_proto();
      set_cfg(2, 4, 3, 3, 1, 1);
      do_reset();
      issue(2'b10, 1'b1);
      chk("R9 write closed err", int'(proto_err), 1);
      for (int k = 1; k <= 10; k++) begin
         chk("R9 closed no pulse", int'(pre_start), 0);
         @(negedge clk);
      end
      chk("R9 still closed", int'(bank_state), 0);
      do_reset();
      issue(2'b01, 1'b0);
      issue(2'b10, 1'b1);
      issue(2'b10, 1'b1);
      chk("R9 double ap err", int'(proto_err), 1);
      for (int k = 1; k <= 8; k++) begin
         chk("R9 first ap timing", int'(pre_start), int'(k == 7));
         @(negedge clk);
      end
   endtask

   task automatic t_plain();
      set_cfg(2, 4, 3, 3, 1, 1);
      do_reset();
      issue(2'b01, 1'b0);
      issue(2'b10, 1'b0);
      for (int k = 0; k <= 14; k++) begin
         chk("R9 plain no pulse", int'(pre_start), 0);
         @(negedge clk);
      end
      chk("R9 plain open", int'(bank_state), 1);
      chk("R9 plain no err", int'(proto_err), 0);
      chk("R9 plain not ready", int'(act_ready), 0);
   endtask

   task automatic t_cfg();
      for (int w = 0; w <= 8; w++) begin
         cfg_wr = CW'(w);
         #1;
         chk("R4 wr range", int'(cfg_err), int'(w < 2 || w > 6));
      end
      cfg_wr = 6'd3;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_wl2();
      t_wl4();
      t_trc();
      t_tras();
      t_reopen();
      t_early_act();
      t_proto();
      t_plain();
      t_cfg();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule